// File: doc/BRIEF.md
# Folded-Range Cartridge Bank Controller

This block sits between an 8-bit CPU bus with a 16-bit address and the memories of a plug-in cartridge. It turns each CPU address into a ROM address and a RAM address, and steers the returned byte back onto the bus. The 32 KB ROM region `0x0000`–`0x7FFF` is seen through two 16 KB windows. The lower window always shows bank 0. The upper window shows one bank chosen by a single 5-bit selector.

Software loads the selector by writing any byte into `0x2000`–`0x3FFF`. Only the low five data bits count. A zero is turned into 1. Any value above 15 is then reduced by 8, so the reachable banks are 1–15 and 8–23. Writes to the rest of the ROM region change nothing. The single 8 KB RAM at `0xA000`–`0xBFFF` is not banked and has no enable gate. When the build has no RAM fitted, reads there return `0xFF`. The memories themselves live outside the block.

Top module: `fold_bank_ctrl`

## Requirements
- R1: Reset (active-low `rstN`) sets the upper-window bank to 1, so a read of `0x4000`+n maps to ROM address `0x4000`+n.
- R2: A write with `busAddr` in `0x0000`–`0x1FFF` leaves the bank unchanged.
- R3: A write with `busAddr` in `0x2000`–`0x3FFF` loads the bank from the low 5 bits of `busWrData` on the next clock edge. A zero value loads 1.
- R4: After the zero correction, a 5-bit value greater than 15 is stored minus 8. For example, 16 is stored as 8 and 31 is stored as 23.
- R5: A write with `busAddr` in `0x4000`–`0x7FFF` leaves the bank unchanged.
- R6: For `busAddr` in `0x0000`–`0x3FFF`, `romAddr` equals `busAddr[13:0]` with all bank bits zero.
- R7: For `busAddr` in `0x4000`–`0x7FFF`, `romAddr` equals bank × 16384 + `busAddr[13:0]`.
- R8: For `busAddr` in `0xA000`–`0xBFFF`, a fitted build does three things: it raises `ramSel`, drives `ramAddr` = `busAddr[12:0]`, and raises `ramWrEn` exactly when `busWrEn` is high. No prior enable write is needed. Outside that range, `ramSel` and `ramWrEn` are low.
- R9: `busRdData` follows three rules. It carries `romRdData` for `busAddr` below `0x8000`. It carries `ramRdData` in the RAM range of a fitted build. It is `0xFF` in the RAM range of an unfitted build and at every other address.
- R10: The stored bank is never 0 and never above 23 (`0x17`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 16 | CPU address |
| busWrData | input | 8 | CPU write data |
| busWrEn | input | 1 | CPU write strobe, sampled on the rising clock edge |
| romRdData | input | 8 | Byte returned by the ROM at `romAddr` |
| ramRdData | input | 8 | Byte returned by the RAM at `ramAddr` |
| romAddr | output | 19 | ROM byte address (bank in the top 5 bits) |
| ramAddr | output | 13 | RAM byte address |
| ramSel | output | 1 | The access targets fitted RAM |
| ramWrEn | output | 1 | Write strobe to the RAM |
| busRdData | output | 8 | Byte returned to the CPU |

## Verification
The bench builds two copies side by side on the same stimulus: the default build with `RAM_FITTED` = 1 and a second build with `RAM_FITTED` = 0. The fitted copy exercises RAM address pass-through and the write strobe with no enable step. The unfitted copy is the only way to reach the `0xFF` return in the RAM range. Both copies keep the default 5-bit selector, fold limit 15 and fold step 8. This lets a sweep of all 256 data bytes written into the selector range reach every corrected and folded bank value up to 23.

// File: rtl/fold_bank_pkg.sv
package fold_bank_pkg;

  // Region codes taken from the top three address bits
  localparam logic [2:0] REGION_IGNORE_LO = 3'b000;
  localparam logic [2:0] REGION_BANK_SEL  = 3'b001;
  localparam logic [2:0] REGION_RAM       = 3'b101;

  // Strobes passed from the decoder to the datapath
  typedef struct packed {
    logic bankLoad;  // write lands in the selector range
    logic romHit;    // address inside the 32 KB ROM region
    logic upperWin;  // ROM access through the switchable window
    logic ramHit;    // address inside the RAM range
    logic ramWrite;  // write lands in the RAM range
  } fold_strobe_t;

endpackage

// File: rtl/fold_bank_decode.sv
module fold_bank_decode
  import fold_bank_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output fold_strobe_t      strobes
);

  localparam int TOP = ADDR_W - 1;

  logic [2:0] region;
  logic       inRom;

  assign region = busAddr[TOP -: 3];
  assign inRom  = ~busAddr[TOP];

  always_comb begin
    strobes          = '0;
    strobes.romHit   = inRom;
    strobes.upperWin = inRom & busAddr[TOP-1];
    strobes.bankLoad = busWrEn & (region == REGION_BANK_SEL);
    strobes.ramHit   = (region == REGION_RAM);
    strobes.ramWrite = busWrEn & (region == REGION_RAM);
  end

endmodule

// File: rtl/fold_bank_reg.sv
module fold_bank_reg
  import fold_bank_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BANK_W     = 5,
  parameter int FOLD_LIMIT = 15,
  parameter int FOLD_STEP  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fold_strobe_t      strobes,
  input  logic [DATA_W-1:0] busWrData,
  output logic [BANK_W-1:0] curBank
);

  localparam logic [BANK_W-1:0] LIMIT     = BANK_W'(FOLD_LIMIT);
  localparam logic [BANK_W-1:0] STEP      = BANK_W'(FOLD_STEP);
  localparam logic [BANK_W-1:0] RESET_VAL = BANK_W'(1);

  logic [BANK_W-1:0] rawSel;
  logic [BANK_W-1:0] nonZeroSel;
  logic [BANK_W-1:0] foldedSel;
  logic [BANK_W-1:0] bankQ;

  assign rawSel     = busWrData[BANK_W-1:0];
  assign nonZeroSel = (rawSel == '0) ? RESET_VAL : rawSel;
  assign foldedSel  = (nonZeroSel > LIMIT) ? (nonZeroSel - STEP) : nonZeroSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      bankQ <= RESET_VAL;
    else if (strobes.bankLoad)
      bankQ <= foldedSel;
  end

  assign curBank = bankQ;

endmodule

// File: rtl/fold_bank_dp.sv
module fold_bank_dp
  import fold_bank_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BANK_W     = 5,
  parameter int WIN_W      = 14,
  parameter int RAM_AW     = 13,
  parameter bit RAM_FITTED = 1'b1
) (
  input  fold_strobe_t             strobes,
  input  logic [WIN_W-1:0]         winOffset,
  input  logic [BANK_W-1:0]        curBank,
  input  logic [DATA_W-1:0]        romRdData,
  input  logic [DATA_W-1:0]        ramRdData,
  output logic [BANK_W+WIN_W-1:0]  romAddr,
  output logic [RAM_AW-1:0]        ramAddr,
  output logic                     ramSel,
  output logic                     ramWrEn,
  output logic [DATA_W-1:0]        busRdData
);

  localparam logic [DATA_W-1:0] OPEN_BUS = '1;

  logic [BANK_W-1:0] winBank;

  // Lower window is hard-wired to bank zero
  assign winBank = strobes.upperWin ? curBank : '0;
  assign romAddr = {winBank, winOffset};
  assign ramAddr = winOffset[RAM_AW-1:0];

  generate
    if (RAM_FITTED) begin : g_ram
      assign ramSel  = strobes.ramHit;
      assign ramWrEn = strobes.ramWrite;
      always_comb begin
        if (strobes.romHit)      busRdData = romRdData;
        else if (strobes.ramHit) busRdData = ramRdData;
        else                     busRdData = OPEN_BUS;
      end
    end else begin : g_noram
      assign ramSel  = 1'b0;
      assign ramWrEn = 1'b0;
      always_comb begin
        if (strobes.romHit) busRdData = romRdData;
        else                busRdData = OPEN_BUS;
      end
    end
  endgenerate

endmodule

// File: rtl/fold_bank_ctrl.sv
module fold_bank_ctrl
  import fold_bank_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int BANK_W     = 5,
  parameter int WIN_W      = 14,
  parameter int RAM_AW     = 13,
  parameter int FOLD_LIMIT = 15,
  parameter int FOLD_STEP  = 8,
  parameter bit RAM_FITTED = 1'b1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic [DATA_W-1:0]       busWrData,
  input  logic                    busWrEn,
  input  logic [DATA_W-1:0]       romRdData,
  input  logic [DATA_W-1:0]       ramRdData,
  output logic [BANK_W+WIN_W-1:0] romAddr,
  output logic [RAM_AW-1:0]       ramAddr,
  output logic                    ramSel,
  output logic                    ramWrEn,
  output logic [DATA_W-1:0]       busRdData
);

  fold_strobe_t      strobes;
  logic [BANK_W-1:0] curBank;

  fold_bank_decode #(.ADDR_W(ADDR_W)) i_decode (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobes (strobes)
  );

  fold_bank_reg #(
    .DATA_W(DATA_W), .BANK_W(BANK_W),
    .FOLD_LIMIT(FOLD_LIMIT), .FOLD_STEP(FOLD_STEP)
  ) i_bank (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busWrData (busWrData),
    .curBank   (curBank)
  );

  fold_bank_dp #(
    .DATA_W(DATA_W), .BANK_W(BANK_W), .WIN_W(WIN_W),
    .RAM_AW(RAM_AW), .RAM_FITTED(RAM_FITTED)
  ) i_dp (
    .strobes   (strobes),
    .winOffset (busAddr[WIN_W-1:0]),
    .curBank   (curBank),
    .romRdData (romRdData),
    .ramRdData (ramRdData),
    .romAddr   (romAddr),
    .ramAddr   (ramAddr),
    .ramSel    (ramSel),
    .ramWrEn   (ramWrEn),
    .busRdData (busRdData)
  );

endmodule

// File: rtl/fold_bank_chk.sv
module fold_bank_chk #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int BANK_W     = 5,
  parameter int WIN_W      = 14,
  parameter int FOLD_LIMIT = 15,
  parameter int FOLD_STEP  = 8,
  parameter bit RAM_FITTED = 1'b1
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [ADDR_W-1:0]       busAddr,
  input logic [DATA_W-1:0]       busWrData,
  input logic                    busWrEn,
  input logic [BANK_W-1:0]       curBank,
  input logic [BANK_W+WIN_W-1:0] romAddr,
  input logic                    ramSel,
  input logic                    ramWrEn,
  input logic [DATA_W-1:0]       busRdData
);

  localparam int TOP     = ADDR_W - 1;
  localparam int MAX_BNK = (1 << BANK_W) - 1 - FOLD_STEP;

  logic selWrite;
  logic [BANK_W-1:0] wrSel;
  assign selWrite = busWrEn && (busAddr[TOP -: 3] == 3'b001);
  assign wrSel    = busWrData[BANK_W-1:0];

  assert_reset_bank_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (curBank == BANK_W'(1)));

  assert_ignore_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr[TOP -: 3] == 3'b000) |=> $stable(curBank));

  assert_zero_fix_R3: assert property (@(posedge clk) disable iff (!rstN)
    (selWrite && wrSel == '0) |=> (curBank == BANK_W'(1)));

  assert_fold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (selWrite && int'(wrSel) > FOLD_LIMIT) |=>
      (int'(curBank) == int'($past(wrSel)) - FOLD_STEP));

  assert_ignore_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr[TOP -: 2] == 2'b01) |=> $stable(curBank));

  assert_lower_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[TOP -: 2] == 2'b00) |-> (romAddr[BANK_W+WIN_W-1 -: BANK_W] == '0));

  assert_ram_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    ramWrEn |-> (ramSel && busWrEn && busAddr[TOP -: 3] == 3'b101));

  assert_open_bus_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!RAM_FITTED && busAddr[TOP -: 3] == 3'b101) |-> (busRdData == '1 && !ramSel));

  assert_bank_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    (curBank != '0) && (int'(curBank) <= MAX_BNK));

endmodule

bind fold_bank_ctrl fold_bank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .WIN_W(WIN_W),
  .FOLD_LIMIT(FOLD_LIMIT), .FOLD_STEP(FOLD_STEP), .RAM_FITTED(RAM_FITTED)
) i_fold_bank_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
  .busWrEn(busWrEn), .curBank(curBank), .romAddr(romAddr),
  .ramSel(ramSel), .ramWrEn(ramWrEn), .busRdData(busRdData)
);

// File: tb/test_fold_bank_ctrl.sv
`timescale 1ns/1ps
module test_fold_bank_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic        busWrEn = 1'b0;
  logic [7:0]  romRdData = '0;
  logic [7:0]  ramRdData = '0;

  logic [18:0] romAddrA, romAddrB;
  logic [12:0] ramAddrA, ramAddrB;
  logic        ramSelA, ramSelB, ramWrEnA, ramWrEnB;
  logic [7:0]  rdA, rdB;

  always #5 clk = ~clk;

  fold_bank_ctrl i_fold_bank_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .romRdData(romRdData), .ramRdData(ramRdData),
    .romAddr(romAddrA), .ramAddr(ramAddrA), .ramSel(ramSelA),
    .ramWrEn(ramWrEnA), .busRdData(rdA)
  );

  fold_bank_ctrl #(.RAM_FITTED(1'b0)) i_fold_bank_ctrl_noram (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .romRdData(romRdData), .ramRdData(ramRdData),
    .romAddr(romAddrB), .ramAddr(ramAddrB), .ramSel(ramSelB),
    .ramWrEn(ramWrEnB), .busRdData(rdB)
  );

  int    checks = 0;
  int    fails  = 0;
  int    modelBank = 1;
  string curTag = "R1";
  bit    finished = 1'b0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (addr 0x%04h)", req, act, exp, busAddr);
    end
  endtask

  function automatic int foldRef(int d);
    int v;
    v = d % 32;
    if (v == 0) v = 1;
    if (v > 15) v = v - 8;
    return v;
  endfunction

  // Compare both builds against the behavioural model
  task automatic compareAll();
    int a;
    int expRom;
    bit inRam;
    a = int'(busAddr);
    inRam = (a >= 'hA000) && (a <= 'hBFFF);
    if (a < 'h8000) begin
      expRom = (a < 'h4000) ? (a % 16384) : (modelBank * 16384 + a % 16384);
      chk((a < 'h4000) ? "R6" : curTag, int'(romAddrA), expRom);
      chk((a < 'h4000) ? "R6" : curTag, int'(romAddrB), expRom);
      if (a >= 'h4000) begin
        chk("R10", int'((romAddrA >> 14) != 0 && (romAddrA >> 14) <= 23), 1);
        chk("R7", int'(romAddrA >> 14), modelBank);
      end
    end
    chk("R8", int'(ramSelA), int'(inRam));
    chk("R8", int'(ramWrEnA), int'(inRam && busWrEn));
    chk("R8", int'(ramSelB), 0);
    chk("R8", int'(ramWrEnB), 0);
    if (inRam) chk("R8", int'(ramAddrA), a % 8192);
    chk("R9", int'(rdA), (a < 'h8000) ? int'(romRdData) : (inRam ? int'(ramRdData) : 'hFF));
    chk("R9", int'(rdB), (a < 'h8000) ? int'(romRdData) : 'hFF);
  endtask

  task automatic step(int a, int d, bit w);
    busAddr   = 16'(a);
    busWrData = 8'(d);
    busWrEn   = w;
    romRdData = 8'(a) ^ 8'h5A;
    ramRdData = 8'(a >> 8) ^ 8'(a) ^ 8'hC3;
    #2;
    compareAll();
    @(posedge clk);
    #1;
    if (!rstN) modelBank = 1;
    else if (w && a >= 'h2000 && a <= 'h3FFF) modelBank = foldRef(d);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    // R1: bank one while held in reset and right after release
    curTag = "R1";
    step('h4123, 0, 0);
    step('h2000, 'h07, 1);
    rstN = 1'b1;
    step('h4000, 0, 0);
    step('h7FFF, 0, 0);
    // R6: lower window under several patterns
    step('h0000, 0, 0);
    step('h1234, 0, 0);
    step('h3FFF, 0, 0);
    // R3: a plain load through the top of the range
    curTag = "R3";
    step('h3FFF, 'h05, 1);
    step('h4321, 0, 0);
    // R2: writes below the selector range have no effect
    curTag = "R2";
    step('h0000, 'h0A, 1);
    step('h1FFF, 'h1C, 1);
    step('h4ABC, 0, 0);
    // R5: writes above the selector range have no effect
    curTag = "R5";
    step('h4000, 'h13, 1);
    step('h5FFF, 'h02, 1);
    step('h7FFF, 'h1F, 1);
    step('h6000, 0, 0);
    // R3/R4: every data byte into the selector range
    for (int d = 0; d < 256; d++) begin
      curTag = ((d % 32) > 15) ? "R4" : "R3";
      step((d % 2 == 0) ? 'h2000 : 'h2000 + (d * 53) % 8192, d, 1);
      step('h4000 + (d * 37) % 16384, 0, 0);
    end
    // R4: explicit folding boundaries
    curTag = "R4";
    step('h2000, 'h10, 1);
    step('h4001, 0, 0);
    step('h2000, 'h1F, 1);
    step('h7FFE, 0, 0);
    curTag = "R3";
    step('h2000, 'h20, 1);
    step('h4002, 0, 0);
    // R8: RAM writes and reads with no enable step
    for (int i = 0; i < 8; i++) begin
      step('hA000 + i * 1031, i * 17, 1);
      step('hA000 + i * 1031, 0, 0);
    end
    step('hBFFF, 'h44, 1);
    // R9: unmapped addresses return open bus
    step('h8000, 0, 0);
    step('hC000, 0, 0);
    step('hFFFF, 'h12, 1);
    // R1: a second reset returns the bank to one
    curTag = "R1";
    rstN = 1'b0;
    step('h5555, 0, 0);
    rstN = 1'b1;
    step('h5555, 0, 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule